// File: doc/BRIEF.md
# Clock Control Register Stub

This block stands in for a clock and reset controller on a memory-mapped register bus. It has no oscillators, no PLL and no clock switching logic. It holds four 32-bit configuration words: one for the on-chip oscillator, one for the crystal oscillator, one for the PLL, and one for the PLL output divider. Boot firmware programs the clock tree through these words and polls the status bits. The stub keeps every value written to it but always reports the oscillators as ready and the PLL as locked, so the polling loops exit at once.

The bus is a single-cycle strobe interface with one access per cycle. The access strobe `bus_sel` together with `bus_we` marks a write, and `bus_sel` without `bus_we` marks a read. Read data and the error flag are registered and appear in the cycle after the strobe. The block decodes a 32 KiB byte window. An aligned access outside the four registers, or any misaligned access, raises the error flag and has no effect on the registers.

Top module: `clkstub_regs`

## Requirements
- R1: After reset the four words read as follows: offset 0x0 reads 0xC000_0000, offset 0x4 reads 0xC000_0000, offset 0x8 reads 0x8006_0000 (bits 31, 18 and 17 set), and offset 0xC reads 0x0000_0100.
- R2: Byte offset 0x0 selects the on-chip oscillator word, 0x4 the crystal oscillator word, 0x8 the PLL word and 0xC the divider word. A write to one of them changes no other word.
- R3: In both oscillator words, bit 31 (ready) reads 1 after any write. Bits 30..0 read back exactly as written, including bit 30 (enable).
- R4: In the PLL word, bit 31 (lock) reads 1 after any write. Bits 30..0 read back exactly as written, including bit 16 (PLL select), bit 17 (reference select) and bit 18 (bypass).
- R5: The divider word stores all 32 written bits unmodified.
- R6: `bus_rdata` carries the addressed word in the cycle after a read strobe. In every other cycle `bus_rdata` is zero.
- R7: An aligned access to any offset in the window other than 0x0, 0x4, 0x8 and 0xC raises `bus_err` for the one following cycle. For that access `bus_rdata` is zero and no word changes.
- R8: An access with address bits [1:0] not zero is an error and is handled as in R7.
- R9: A write takes effect at the clock edge that samples it. A read strobed in the next cycle returns the new value with the forced bits applied.
- R10: `rst` is active high and synchronous. At the first edge that samples it high, every word returns to its R1 value, and `bus_err` and `bus_rdata` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | With bus_sel: 1 = write, 0 = read |
| bus_addr | input | ADDR_W (15) | Byte offset inside the window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data; zero when no valid read occurred |
| bus_err | output | 1 | Registered one-cycle error for an unmapped or misaligned access |

## Verification
Each word is written with all zeros, all ones, alternating nibble patterns and an arbitrary value, then read back at once. All zeros exposes the forced status bits. All ones and the alternating patterns show whether any other bit is masked, dropped or swapped, such as the enable bit next to the ready bit or the PLL control bits. Unmapped offsets near the registers, at the far end of the window and at misaligned addresses are read and written, then all four words are read back to show that nothing changed. A reset in mid-run is also applied to confirm that the reset values return.

// File: rtl/clkstub_pkg.sv
package clkstub_pkg;

   localparam int unsigned CS_DATA_W = 32;
   localparam int unsigned CS_NREG   = 4;

   // register indices, equal to byte offset >> 2
   localparam int unsigned IDX_ROSC = 0;
   localparam int unsigned IDX_XOSC = 1;
   localparam int unsigned IDX_PLL  = 2;
   localparam int unsigned IDX_DIV  = 3;

   // field positions
   localparam int unsigned OSC_RDY_BIT  = 31;
   localparam int unsigned OSC_EN_BIT   = 30;
   localparam int unsigned PLL_SEL_BIT  = 16;
   localparam int unsigned PLL_REF_BIT  = 17;
   localparam int unsigned PLL_BYP_BIT  = 18;
   localparam int unsigned PLL_LOCK_BIT = 31;
   localparam int unsigned DIV_ONE_BIT  = 8;

   function automatic logic [CS_DATA_W-1:0] bitmask(input int unsigned pos);
      logic [CS_DATA_W-1:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction

   // value after reset for register i
   function automatic logic [CS_DATA_W-1:0] cs_reset_val(input int unsigned i);
      case (i)
         IDX_ROSC, IDX_XOSC: return bitmask(OSC_RDY_BIT) | bitmask(OSC_EN_BIT);
         IDX_PLL:            return bitmask(PLL_LOCK_BIT) | bitmask(PLL_BYP_BIT)
                                  | bitmask(PLL_REF_BIT);
         default:            return bitmask(DIV_ONE_BIT);
      endcase
   endfunction

   // bits that always read one for register i
   function automatic logic [CS_DATA_W-1:0] cs_force_mask(input int unsigned i);
      case (i)
         IDX_ROSC, IDX_XOSC: return bitmask(OSC_RDY_BIT);
         IDX_PLL:            return bitmask(PLL_LOCK_BIT);
         default:            return '0;
      endcase
   endfunction

endpackage

// File: rtl/clkstub_decode.sv
module clkstub_decode #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned NREG   = 4,
   localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output logic [NREG-1:0]   onehot
);
   localparam int unsigned HI_LSB = IDX_W + 2;

   generate
      if (ADDR_W <= HI_LSB) begin : g_bad_w
         $error("clkstub_decode: ADDR_W too small for register count");
      end
      if ((1 << IDX_W) != NREG) begin : g_bad_n
         $error("clkstub_decode: NREG must be a power of two");
      end
   endgenerate

   logic aligned;
   logic in_range;

   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = (addr[ADDR_W-1:HI_LSB] == '0);
   assign idx      = addr[HI_LSB-1:2];
   assign hit      = aligned && in_range;

   for (genvar g = 0; g < NREG; g++) begin : g_sel
      assign onehot[g] = sel && hit && (idx == IDX_W'(g));
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(onehot)); // R2
   AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      !sel |-> (onehot == '0)); // R2
endmodule

// File: rtl/clkstub_cfg_reg.sv
module clkstub_cfg_reg #(
   parameter int unsigned          W     = 32,
   parameter logic [W-1:0]         RESET = '0,
   parameter logic [W-1:0]         FORCE = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   generate
      if ((RESET & FORCE) != FORCE) begin : g_bad_rst
         $error("clkstub_cfg_reg: reset value must have forced bits set");
      end
   endgenerate

   logic [W-1:0] store;

   // forced bits are folded in at write time so the stored word is what is read
   always_ff @(posedge clk) begin
      if (rst)        store <= RESET;
      else if (wr_en) store <= wdata | FORCE;
   end

   assign q = store;

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (q == ($past(wdata) | FORCE))); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(q)); // R7
endmodule

// File: rtl/clkstub_readback.sv
module clkstub_readback #(
   parameter int unsigned W     = 32,
   parameter int unsigned NREG  = 4,
   localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     rd_ok,
   input  logic                     bad,
   input  logic [IDX_W-1:0]         idx,
   input  logic [NREG-1:0][W-1:0]   words,
   output logic [W-1:0]             rdata,
   output logic                     err
);
   logic [W-1:0] picked;

   always_comb begin
      picked = '0;
      for (int i = 0; i < NREG; i++) begin
         if (idx == IDX_W'(i)) picked = words[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         rdata <= rd_ok ? picked : '0;
         err   <= bad;
      end
   end

   AST_ERR_FOLLOWS_BAD: assert property (@(posedge clk) disable iff (rst)
      bad |=> err); // R7
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
      err |-> (rdata == '0)); // R7
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !rd_ok |=> (rdata == '0)); // R6
endmodule

// File: rtl/clkstub_regs.sv
module clkstub_regs
   import clkstub_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = CS_DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);
   localparam int unsigned NREG  = CS_NREG;
   localparam int unsigned IDX_W = $clog2(NREG);

   generate
      if (DATA_W != CS_DATA_W) begin : g_bad_dw
         $error("clkstub_regs: field layout requires DATA_W of 32");
      end
   endgenerate

   logic                        hit;
   logic [IDX_W-1:0]            idx;
   logic [NREG-1:0]             sel_oh;
   logic [NREG-1:0][DATA_W-1:0] words;
   logic                        rd_ok;
   logic                        bad;

   clkstub_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .sel    (bus_sel),
      .addr   (bus_addr),
      .hit    (hit),
      .idx    (idx),
      .onehot (sel_oh)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      clkstub_cfg_reg #(
         .W     (DATA_W),
         .RESET (cs_reset_val(g)),
         .FORCE (cs_force_mask(g))
      ) u_reg (
         .clk   (clk),
         .rst   (rst),
         .wr_en (sel_oh[g] && bus_we),
         .wdata (bus_wdata),
         .q     (words[g])
      );
   end

   assign rd_ok = bus_sel && !bus_we && hit;
   assign bad   = bus_sel && !hit;

   clkstub_readback #(.W(DATA_W), .NREG(NREG)) u_rb (
      .clk   (clk),
      .rst   (rst),
      .rd_ok (rd_ok),
      .bad   (bad),
      .idx   (idx),
      .words (words),
      .rdata (bus_rdata),
      .err   (bus_err)
   );

   AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && !hit) |=> $stable(words)); // R7
   AST_MISALIGNED_ERR: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && (bus_addr[1:0] != 2'b00)) |=> bus_err); // R8
   AST_STATUS_READY: assert property (@(posedge clk) disable iff (rst)
      words[IDX_ROSC][OSC_RDY_BIT] && words[IDX_XOSC][OSC_RDY_BIT]); // R3
   AST_PLL_LOCKED: assert property (@(posedge clk) disable iff (rst)
      words[IDX_PLL][PLL_LOCK_BIT]); // R4
   AST_GOOD_NO_ERR: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && hit) |=> !bus_err); // R7
   AST_RESET_VALUES: assert property (@(posedge clk)
      $past(rst) |-> (words[IDX_DIV] == cs_reset_val(IDX_DIV))); // R10
endmodule

// File: tb/clkstub_regs_tb.sv
module clkstub_regs_tb;
   localparam int AW = 15;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] model [4];

   always #10 clk = ~clk;

   clkstub_regs u_dut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err)
   );

   function automatic logic [31:0] rst_of(int i);
      case (i)
         0, 1: return 32'hC000_0000;
         2:    return 32'h8006_0000;
         default: return 32'h0000_0100;
      endcase
   endfunction

   function automatic logic [31:0] force_of(int i);
      return (i == 3) ? 32'h0 : 32'h8000_0000;
   endfunction

   function automatic string tag_of(int i);
      case (i)
         0, 1: return "R3";
         2:    return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) model[i] = rst_of(i);
   endtask

   // one bus cycle; called at a negedge, returns at the next negedge
   task automatic access(bit sel, bit we, logic [AW-1:0] a, logic [31:0] d,
                         string tag);
      logic [31:0] exp_rd;
      bit exp_err;
      bit good;
      int i;
      bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
      good = (a[1:0] == 2'b00) && (a[AW-1:4] == '0);
      i = int'(a[3:2]);
      exp_rd = 32'h0;
      exp_err = sel && !good;
      @(posedge clk);
      if (sel && good && !we) exp_rd = model[i];
      if (sel && good && we) model[i] = d | force_of(i);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      check({tag, " rdata"}, bus_rdata, exp_rd);
      check({tag, " err"}, {31'b0, bus_err}, {31'b0, exp_err});
   endtask

   task automatic rd(int i);
      access(1'b1, 1'b0, AW'(i * 4), 32'h0, tag_of(i));
   endtask

   task automatic wr(int i, logic [31:0] d);
      access(1'b1, 1'b1, AW'(i * 4), d, "R2");
   endtask

   task automatic read_all(string tag);
      for (int i = 0; i < 4; i++)
         access(1'b1, 1'b0, AW'(i * 4), 32'h0, tag);
   endtask

   initial begin
      logic [31:0] pats [5];
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h5A5A_5A5A; pats[3] = 32'hA5A5_A5A5;
      pats[4] = 32'h7FF8_FEFF;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset values, R10 sync reset
      read_all("R1");
      access(1'b0, 1'b0, '0, 32'h0, "R6");
      // R2..R5, R9: write then read next cycle
      for (int p = 0; p < 5; p++) begin
         for (int i = 0; i < 4; i++) begin
            wr(i, pats[p] ^ (32'h0101_0101 * i));
            rd(i);
         end
         read_all("R2");
      end
      // R4: individual PLL control bits
      wr(2, 32'h0001_0000); rd(2);
      wr(2, 32'h0004_0000); rd(2);
      // R7: unmapped aligned offsets, read and write
      access(1'b1, 1'b0, 15'h0010, 32'h0, "R7");
      access(1'b1, 1'b1, 15'h0010, 32'hDEAD_BEEF, "R7");
      access(1'b1, 1'b1, 15'h7FFC, 32'h1234_5678, "R7");
      access(1'b1, 1'b0, 15'h4000, 32'h0, "R7");
      access(1'b1, 1'b1, 15'h0100, 32'hFFFF_FFFF, "R7");
      read_all("R7");
      // R8: misaligned
      access(1'b1, 1'b1, 15'h0001, 32'h0, "R8");
      access(1'b1, 1'b1, 15'h0006, 32'h0, "R8");
      access(1'b1, 1'b1, 15'h000B, 32'h0, "R8");
      access(1'b1, 1'b0, 15'h000E, 32'h0, "R8");
      read_all("R8");
      // R6: idle cycles
      repeat (3) access(1'b0, 1'b0, 15'h0008, 32'h0, "R6");
      // R10: mid-run reset
      wr(3, 32'h1234_5678);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      check("R10 rdata", bus_rdata, 32'h0);
      check("R10 err", {31'b0, bus_err}, 32'h0);
      read_all("R10");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule